// File: doc/BRIEF.md
# Context-Configured Reconfigurable Cell Datapath

This block is a single processing cell meant to be tiled into a coarse-grain SIMD array. A 32-bit context word, held in a context register inside the cell, sets every control each cycle. These controls cover which sources feed the two ALU operand ports, which arithmetic or logic function runs, which register-file entry takes the result, how the result is shifted, and whether the cell drives its express-lane and data-bus outputs. A 12-bit immediate in the same word acts as a multiplier operand, an addend, a mux source, or a sub-operation selector for the logic group.

The datapath has 16-bit operands and a signed 16 by 12 multiplier. Its 32-bit output register is also the accumulator, so a multiply-accumulate finishes in one cycle. A sign flag records the sign of the port-A operand so that a later context can act on it, as in quantization. A feedback register holds the previous port-A operand. The surrounding array supplies all neighbour, quadrant, express-lane and bus values as plain input ports. The controller loads a context with a strobe and steps the cell with an enable.

Context word layout, most significant bit first: opcode [31:28], A select [27:24], B select [23:21], destination register [20:19], shift direction [18] (1 = left), shift amount [17:14], express-lane write [13], bus write [12], immediate [11:0].

Top module: `rc_cell`

## Requirements
- R1: While rst is high at a clock edge, out_word, sign_flag, xlane_vld, bus_vld, the feedback register and the context register all become 0. A context of 0 means: pass A, A select 0, no shift, no lane or bus write.
- R2: With ctx_load high at an edge, ctx_in is captured and governs every later enabled cycle. With ctx_load low, the held context is kept.
- R3: A select codes: 0 to 3 pick neighbour inputs nbr_in slices 0 to 3; 4 picks quad_row_in; 5 picks quad_col_in; 6 picks xlane_in; 7 picks bus_a_in; 8 picks the feedback register; 9 picks xquad_in; 10 to 13 pick register entries 0 to 3; 14 picks the immediate sign-extended to 16 bits; 15 picks zero.
- R4: B select codes: 0 to 3 pick register entries 0 to 3; 4 picks bus_b_in; 5 to 7 pick nbr_in slices 0 to 2.
- R5: The following opcodes produce signed 16-bit arithmetic results, sign-extended to 32 bits: opcode 0 (A), opcode 1 (A+B), opcode 2 (A−B), opcode 9 (A plus the sign-extended immediate).
- R6: Opcode 3 gives |A−B| of the signed 16-bit operands, zero-extended. The result is never negative.
- R7: Opcode 4 gives A times the signed low 12 bits of B. Opcode 5 gives A times the signed immediate. In both cases the product is sign-extended to 32 bits.
- R8: Opcodes 6 and 7 add the opcode-4 and opcode-5 product respectively to the current out_word, modulo 2^32, in one enabled cycle.
- R9: Opcode 8 selects a logic function by immediate bits [1:0]: 0 gives AND, 1 gives OR, 2 gives XOR, 3 gives NOT A. The 16-bit result is zero-extended.
- R10: Each enabled cycle loads sign_flag with bit 15 of the port-A operand. Opcode 10 gives −A when the flag held before that cycle is 1, and gives A otherwise.
- R11: The 32-bit result is shifted by 0 to 15 bits before it reaches out_word. Direction 1 is a logical left shift; direction 0 is an arithmetic right shift.
- R12: While en is low, out_word, sign_flag, the register file and the feedback register keep their values, and xlane_vld and bus_vld read 0.
- R13: Each enabled cycle writes the low 16 bits of the shifted result to the destination register entry and writes the port-A operand to the feedback register.
- R14: xlane_out and bus_out carry out_word[15:0]. xlane_vld and bus_vld are high in the cycle after an enabled cycle whose context had the matching write bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctx_load | input | 1 | Capture ctx_in into the context register |
| ctx_in | input | 32 | Context word to capture |
| en | input | 1 | Cell enable; high executes the held context |
| nbr_in | input | 64 | Four neighbour outputs, 16 bits each, slice 0 lowest |
| quad_row_in | input | 16 | Quadrant row operand |
| quad_col_in | input | 16 | Quadrant column operand |
| xlane_in | input | 16 | Express-lane operand |
| bus_a_in | input | 16 | Data bus operand for port A |
| bus_b_in | input | 16 | Data bus operand for port B |
| xquad_in | input | 16 | Cross-quadrant operand |
| out_word | output | 32 | Output/accumulator register |
| sign_flag | output | 1 | Recorded sign of the port-A operand |
| xlane_out | output | 16 | Express-lane drive value |
| xlane_vld | output | 1 | Express-lane drive valid |
| bus_out | output | 16 | Data bus drive value |
| bus_vld | output | 1 | Data bus drive valid |

## Verification
The assertions assume that rst is applied for at least one edge before any other activity, and that the opcode and select inputs are known values at each edge. They also assume the register file is written before the design reads it. The bench holds rst high for several edges and drives only defined context words. Before any code selects register entries 10 to 13 or B codes 0 to 3, the bench preloads every register entry through enabled pass-A cycles. It changes the context strobe and the enable only on falling edges and keeps them apart, so each enabled cycle runs exactly one known context.

// File: rtl/rc_pkg.sv
package rc_pkg;
  localparam int DW   = 16;
  localparam int KW   = 12;
  localparam int OW   = 32;
  localparam int NREG = 4;
  localparam int NSA  = 16;
  localparam int NSB  = 8;

  localparam logic [3:0] OP_PASSA = 4'd0;
  localparam logic [3:0] OP_ADD   = 4'd1;
  localparam logic [3:0] OP_SUB   = 4'd2;
  localparam logic [3:0] OP_ABSD  = 4'd3;
  localparam logic [3:0] OP_MUL   = 4'd4;
  localparam logic [3:0] OP_MULK  = 4'd5;
  localparam logic [3:0] OP_MAC   = 4'd6;
  localparam logic [3:0] OP_MACK  = 4'd7;
  localparam logic [3:0] OP_LOGIC = 4'd8;
  localparam logic [3:0] OP_ADDK  = 4'd9;
  localparam logic [3:0] OP_SGNA  = 4'd10;

  typedef struct packed {
    logic [3:0]      op;
    logic [3:0]      sel_a;
    logic [2:0]      sel_b;
    logic [1:0]      dst;
    logic            sh_left;
    logic [3:0]      sh_amt;
    logic            lane_we;
    logic            bus_we;
    logic [KW-1:0]   imm;
  } rc_ctx_t;
endpackage

// File: rtl/rc_opmux.sv
module rc_opmux
  import rc_pkg::*;
#(
  parameter int W  = DW,
  parameter int KB = KW,
  parameter int NR = NREG
) (
  input  logic [4*W-1:0]  nbr_in,
  input  logic [W-1:0]    row_in,
  input  logic [W-1:0]    col_in,
  input  logic [W-1:0]    lane_in,
  input  logic [W-1:0]    bus_a,
  input  logic [W-1:0]    bus_b,
  input  logic [W-1:0]    xq_in,
  input  logic [W-1:0]    fb,
  input  logic [NR*W-1:0] rf_flat,
  input  logic [KB-1:0]   imm,
  input  logic [3:0]      sel_a,
  input  logic [2:0]      sel_b,
  output logic [W-1:0]    opa,
  output logic [W-1:0]    opb
);
  logic [W-1:0] src_a [NSA];
  logic [W-1:0] src_b [NSB];

  for (genvar i = 0; i < 4; i++) begin : g_nbr_a
    assign src_a[i] = nbr_in[i*W +: W];
  end
  for (genvar i = 0; i < NR; i++) begin : g_rf
    assign src_a[10+i] = rf_flat[i*W +: W];
    assign src_b[i]    = rf_flat[i*W +: W];
  end
  for (genvar i = 0; i < 3; i++) begin : g_nbr_b
    assign src_b[5+i] = nbr_in[i*W +: W];
  end
  assign src_a[4]  = row_in;
  assign src_a[5]  = col_in;
  assign src_a[6]  = lane_in;
  assign src_a[7]  = bus_a;
  assign src_a[8]  = fb;
  assign src_a[9]  = xq_in;
  assign src_a[14] = {{(W-KB){imm[KB-1]}}, imm};
  assign src_a[15] = '0;
  assign src_b[4]  = bus_b;

  assign opa = src_a[sel_a];
  assign opb = src_b[sel_b];
endmodule

// File: rtl/rc_regfile.sv
module rc_regfile
  import rc_pkg::*;
#(
  parameter int W  = DW,
  parameter int NR = NREG,
  localparam int AW = $clog2(NR)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [W-1:0]    wdata,
  output logic [NR*W-1:0] rd_flat
);
  logic [W-1:0] mem [NR];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar i = 0; i < NR; i++) begin : g_rd
    assign rd_flat[i*W +: W] = mem[i];
  end
endmodule

// File: rtl/rc_alu.sv
module rc_alu
  import rc_pkg::*;
#(
  parameter int W  = DW,
  parameter int KB = KW,
  parameter int OWD = OW,
  localparam int PW = W + KB
) (
  input  logic [3:0]     op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic [KB-1:0]  imm,
  input  logic [OWD-1:0] acc,
  input  logic           flag,
  output logic [OWD-1:0] res
);
  logic signed [W-1:0]  sa;
  logic signed [KB-1:0] m2;
  logic signed [PW-1:0] prod;
  logic [W:0]           sum, dif, adk, mag;
  logic [OWD-1:0]       a_x, prod_x;
  logic [W-1:0]         lg;

  assign sa     = a;
  assign m2     = (op == OP_MULK || op == OP_MACK) ? imm : b[KB-1:0];
  assign prod   = sa * m2;
  assign sum    = {a[W-1], a} + {b[W-1], b};
  assign dif    = {a[W-1], a} - {b[W-1], b};
  assign adk    = {a[W-1], a} + {{(W+1-KB){imm[KB-1]}}, imm};
  assign mag    = dif[W] ? (~dif + 1'b1) : dif;
  assign a_x    = {{(OWD-W){a[W-1]}}, a};
  assign prod_x = {{(OWD-PW){prod[PW-1]}}, prod};

  always_comb begin
    case (imm[1:0])
      2'd0:    lg = a & b;
      2'd1:    lg = a | b;
      2'd2:    lg = a ^ b;
      default: lg = ~a;
    endcase
  end

  always_comb begin
    case (op)
      OP_ADD:            res = {{(OWD-W-1){sum[W]}}, sum};
      OP_SUB:            res = {{(OWD-W-1){dif[W]}}, dif};
      OP_ABSD:           res = {{(OWD-W-1){1'b0}}, mag};
      OP_MUL, OP_MULK:   res = prod_x;
      OP_MAC, OP_MACK:   res = acc + prod_x;
      OP_LOGIC:          res = {{(OWD-W){1'b0}}, lg};
      OP_ADDK:           res = {{(OWD-W-1){adk[W]}}, adk};
      OP_SGNA:           res = flag ? (~a_x + 1'b1) : a_x;
      default:           res = a_x;
    endcase
  end

  always_comb begin
    if (op == OP_ABSD)
      assert_absd_nonneg_R6: assert (res[OWD-1:W+1] == '0);
  end
endmodule

// File: rtl/rc_shift.sv
module rc_shift
  import rc_pkg::*;
#(
  parameter int OWD = OW
) (
  input  logic [OWD-1:0] din,
  input  logic           left,
  input  logic [3:0]     amt,
  output logic [OWD-1:0] dout
);
  logic signed [OWD-1:0] sdin;
  assign sdin = din;
  assign dout = left ? (din << amt) : OWD'(sdin >>> amt);

  always_comb begin
    if (amt == 4'd0)
      assert_zero_shift_R11: assert (dout == din);
  end
endmodule

// File: rtl/rc_cell.sv
module rc_cell
  import rc_pkg::*;
#(
  parameter int W   = DW,
  parameter int KB  = KW,
  parameter int OWD = OW,
  parameter int NR  = NREG
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ctx_load,
  input  logic [31:0]    ctx_in,
  input  logic           en,
  input  logic [4*W-1:0] nbr_in,
  input  logic [W-1:0]   quad_row_in,
  input  logic [W-1:0]   quad_col_in,
  input  logic [W-1:0]   xlane_in,
  input  logic [W-1:0]   bus_a_in,
  input  logic [W-1:0]   bus_b_in,
  input  logic [W-1:0]   xquad_in,
  output logic [OWD-1:0] out_word,
  output logic           sign_flag,
  output logic [W-1:0]   xlane_out,
  output logic           xlane_vld,
  output logic [W-1:0]   bus_out,
  output logic           bus_vld
);
  rc_ctx_t        ctx_q;
  logic [OWD-1:0] out_q, alu_res, shifted;
  logic [W-1:0]   opa, opb, fb_q;
  logic [NR*W-1:0] rf_flat;
  logic           flag_q, lane_q, busv_q;

  always_ff @(posedge clk) begin
    if (rst)           ctx_q <= '0;
    else if (ctx_load) ctx_q <= ctx_in;
  end

  rc_opmux #(.W(W), .KB(KB), .NR(NR)) u_mux (
    .nbr_in(nbr_in), .row_in(quad_row_in), .col_in(quad_col_in),
    .lane_in(xlane_in), .bus_a(bus_a_in), .bus_b(bus_b_in),
    .xq_in(xquad_in), .fb(fb_q), .rf_flat(rf_flat), .imm(ctx_q.imm),
    .sel_a(ctx_q.sel_a), .sel_b(ctx_q.sel_b), .opa(opa), .opb(opb)
  );

  rc_alu #(.W(W), .KB(KB), .OWD(OWD)) u_alu (
    .op(ctx_q.op), .a(opa), .b(opb), .imm(ctx_q.imm),
    .acc(out_q), .flag(flag_q), .res(alu_res)
  );

  rc_shift #(.OWD(OWD)) u_shift (
    .din(alu_res), .left(ctx_q.sh_left), .amt(ctx_q.sh_amt), .dout(shifted)
  );

  rc_regfile #(.W(W), .NR(NR)) u_rf (
    .clk(clk), .we(en), .waddr(ctx_q.dst), .wdata(shifted[W-1:0]),
    .rd_flat(rf_flat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q  <= '0;
      flag_q <= 1'b0;
      fb_q   <= '0;
      lane_q <= 1'b0;
      busv_q <= 1'b0;
    end else begin
      lane_q <= en & ctx_q.lane_we;
      busv_q <= en & ctx_q.bus_we;
      if (en) begin
        out_q  <= shifted;
        flag_q <= opa[W-1];
        fb_q   <= opa;
      end
    end
  end

  assign out_word  = out_q;
  assign sign_flag = flag_q;
  assign xlane_out = out_q[W-1:0];
  assign bus_out   = out_q[W-1:0];
  assign xlane_vld = lane_q;
  assign bus_vld   = busv_q;

  assert_freeze_R12: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(out_q) && $stable(flag_q) && $stable(fb_q)));

  assert_ctx_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !ctx_load |=> $stable(ctx_q));

  assert_lane_valid_R14: assert property (@(posedge clk) disable iff (rst)
    (xlane_vld || bus_vld) |-> $past(en));
endmodule

// File: tb/tb_rc_cell.sv
module tb_rc_cell;
  logic        clk = 1'b0;
  logic        rst, ctx_load, en;
  logic [31:0] ctx_in;
  logic [15:0] nb [4];
  logic [15:0] row_v, col_v, xl_v, ba_v, bb_v, xq_v;
  logic [31:0] out_word;
  logic        sign_flag, xlane_vld, bus_vld;
  logic [15:0] xlane_out, bus_out;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  logic [31:0] m_out, m_ctx;
  logic        m_flag, m_xv, m_bv;
  logic [15:0] m_fb;
  logic [15:0] m_rf [4];

  always #4 clk = ~clk;

  rc_cell dut (
    .clk(clk), .rst(rst), .ctx_load(ctx_load), .ctx_in(ctx_in), .en(en),
    .nbr_in({nb[3], nb[2], nb[1], nb[0]}), .quad_row_in(row_v),
    .quad_col_in(col_v), .xlane_in(xl_v), .bus_a_in(ba_v), .bus_b_in(bb_v),
    .xquad_in(xq_v), .out_word(out_word), .sign_flag(sign_flag),
    .xlane_out(xlane_out), .xlane_vld(xlane_vld), .bus_out(bus_out),
    .bus_vld(bus_vld)
  );

  function automatic logic [31:0] mk(input int op, sa, sb, dst, sl, amt,
                                     xw, bw, k);
    return {op[3:0], sa[3:0], sb[2:0], dst[1:0], sl[0], amt[3:0],
            xw[0], bw[0], k[11:0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk({tag, " out_word"}, out_word, m_out);
    chk({tag, " sign_flag"}, {31'd0, sign_flag}, {31'd0, m_flag});
    chk({tag, " R14 lane_vld"}, {31'd0, xlane_vld}, {31'd0, m_xv});
    chk({tag, " R14 bus_vld"}, {31'd0, bus_vld}, {31'd0, m_bv});
    chk({tag, " R14 lane_data"}, {16'd0, xlane_out}, {16'd0, m_out[15:0]});
  endtask

  function automatic logic [15:0] pick_a(input logic [3:0] s,
                                         input logic [11:0] k);
    case (s)
      4'd0, 4'd1, 4'd2, 4'd3: return nb[s[1:0]];
      4'd4: return row_v;
      4'd5: return col_v;
      4'd6: return xl_v;
      4'd7: return ba_v;
      4'd8: return m_fb;
      4'd9: return xq_v;
      4'd10, 4'd11, 4'd12, 4'd13: return m_rf[s - 4'd10];
      4'd14: return {{4{k[11]}}, k};
      default: return 16'd0;
    endcase
  endfunction

  function automatic logic [15:0] pick_b(input logic [2:0] s);
    if (s < 3'd4) return m_rf[s[1:0]];
    if (s == 3'd4) return bb_v;
    return nb[s - 3'd5];
  endfunction

  task automatic model_exec(input logic [31:0] c);
    logic [15:0] a, b;
    logic [31:0] r, sh;
    int sa, sb, k, p;
    a  = pick_a(c[27:24], c[11:0]);
    b  = pick_b(c[23:21]);
    sa = $signed(a);
    sb = $signed(b);
    k  = $signed(c[11:0]);
    case (c[31:28])
      4'd1: r = sa + sb;
      4'd2: r = sa - sb;
      4'd3: r = (sa > sb) ? sa - sb : sb - sa;
      4'd4, 4'd6: begin p = sa * $signed(b[11:0]); r = p; end
      4'd5, 4'd7: begin p = sa * k; r = p; end
      4'd8: case (c[1:0])
              2'd0: r = {16'd0, a & b};
              2'd1: r = {16'd0, a | b};
              2'd2: r = {16'd0, a ^ b};
              default: r = {16'd0, ~a};
            endcase
      4'd9: r = sa + k;
      4'd10: r = m_flag ? -sa : sa;
      default: r = sa;
    endcase
    if (c[31:28] == 4'd6 || c[31:28] == 4'd7) r = m_out + r;
    if (c[18]) sh = r << c[17:14];
    else       sh = $signed(r) >>> c[17:14];
    m_out = sh;
    m_rf[c[20:19]] = sh[15:0];
    m_fb = a;
    m_flag = a[15];
    m_xv = c[13];
    m_bv = c[12];
  endtask

  task automatic pulse_en();
    @(negedge clk) en = 1'b1;
    @(negedge clk) en = 1'b0;
    model_exec(m_ctx);
  endtask

  task automatic load_ctx(input logic [31:0] c);
    @(negedge clk) begin ctx_in = c; ctx_load = 1'b1; end
    @(negedge clk) ctx_load = 1'b0;
    m_ctx = c;
    m_xv = 1'b0;
    m_bv = 1'b0;
  endtask

  task automatic run(input logic [31:0] c, input string tag);
    load_ctx(c);
    pulse_en();
    chk_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [15:0] vals [8];
    vals = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF,
             16'h8000, 16'd123, 16'hFED4, 16'h1234};
    rst = 1'b1; ctx_load = 1'b0; en = 1'b0; ctx_in = '0;
    for (int i = 0; i < 4; i++) nb[i] = 16'h1000 + 16'(i * 16'h111);
    row_v = 16'h2468; col_v = 16'h1357; xl_v = 16'h0F0F;
    ba_v = 16'h00AA; bb_v = 16'h5500; xq_v = 16'h9ABC;
    m_out = '0; m_ctx = '0; m_flag = 0; m_xv = 0; m_bv = 0; m_fb = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    chk_all("R1 reset");

    // R1/R2: reset context is pass-A from neighbour 0
    nb[0] = 16'h8ABC;
    pulse_en();
    chk_all("R1 R2 reset context");

    // R2: load only, no execution
    load_ctx(mk(1, 7, 4, 0, 0, 0, 1, 1, 0));
    chk_all("R2 load without enable");
    pulse_en();
    chk_all("R2 loaded context runs");

    // preload register entries for R3/R4/R13
    for (int i = 0; i < 4; i++) begin
      ba_v = 16'hC001 + 16'(i * 16'h0222);
      run(mk(0, 7, 0, i, 0, 0, 0, 0, 0), "R13 preload");
    end
    // R3: every A select code
    for (int s = 0; s < 16; s++)
      run(mk(0, s, 0, (s >= 10 && s <= 13) ? s - 10 : 0, 0, 0, 0, 0, 12'hA35),
          $sformatf("R3 sel_a %0d", s));
    for (int i = 0; i < 4; i++) begin
      ba_v = 16'h3C10 + 16'(i * 16'h0101);
      run(mk(0, 7, 0, i, 0, 0, 0, 0, 0), "R13 preload");
    end
    // R4: every B select code (A = zero, add)
    for (int s = 0; s < 8; s++)
      run(mk(1, 15, s, s % 4, 0, 0, 0, 0, 0), $sformatf("R4 sel_b %0d", s));

    // R5 R6 R7 R8: operand sweeps from the two buses
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++) begin
        ba_v = vals[i]; bb_v = vals[j];
        run(mk(1, 7, 4, 0, 0, 0, 0, 0, 0), "R5 add");
        run(mk(2, 7, 4, 1, 0, 0, 1, 0, 0), "R5 sub");
        run(mk(3, 7, 4, 2, 0, 0, 0, 1, 0), "R6 absd");
        run(mk(4, 7, 4, 3, 0, 0, 0, 0, 0), "R7 mul");
        run(mk(6, 7, 4, 0, 0, 0, 1, 1, 0), "R8 mac");
        run(mk(8, 7, 4, 1, 0, 0, 0, 0, j % 4), "R9 logic");
      end
    for (int i = 0; i < 8; i++)
      for (int kk = 0; kk < 4; kk++) begin
        ba_v = vals[i];
        run(mk(5, 7, 4, 0, 0, 0, 0, 0, 12'h800 + kk * 12'h2F1), "R7 mulk");
        run(mk(7, 7, 4, 0, 0, 0, 0, 0, 12'h7FF - kk * 12'h155), "R8 mack");
        run(mk(9, 7, 4, 0, 0, 0, 0, 0, 12'h801 + kk * 12'h3A7), "R5 addk");
      end
    // R8: repeated accumulation in place
    ba_v = 16'h7FFF; bb_v = 16'h07FF;
    load_ctx(mk(6, 7, 4, 0, 0, 0, 0, 0, 0));
    for (int n = 0; n < 12; n++) begin
      pulse_en();
      chk_all("R8 mac chain");
    end

    // R10: sign flag steers opcode 10
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++) begin
        ba_v = vals[i];
        run(mk(0, 7, 4, 0, 0, 0, 0, 0, 0), "R10 set flag");
        ba_v = vals[j];
        run(mk(10, 7, 4, 0, 0, 0, 0, 0, 0), "R10 sign apply");
      end

    // R11: every shift amount, both directions
    for (int d = 0; d < 2; d++)
      for (int s = 0; s < 16; s++) begin
        ba_v = 16'h9234; bb_v = 16'h0ABC;
        run(mk(4, 7, 4, 0, d, s, 0, 0, 0), $sformatf("R11 shift %0d %0d", d, s));
      end

    // R12: enable low freezes state
    ba_v = 16'h8001; bb_v = 16'h0003;
    run(mk(1, 7, 4, 2, 0, 0, 1, 1, 0), "R12 prior");
    load_ctx(mk(1, 6, 4, 2, 1, 3, 1, 1, 0));
    ba_v = 16'h1111; xl_v = 16'h7777;
    repeat (5) @(negedge clk);
    chk_all("R12 frozen");
    run(mk(0, 8, 0, 3, 0, 0, 0, 0, 0), "R12 R13 feedback held");
    for (int i = 0; i < 4; i++)
      run(mk(0, 10 + i, 0, i, 0, 0, 0, 0, 0), "R12 R13 regfile held");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule